// File: doc/BRIEF.md
# DAC Output Override and Power-Down Controller

This block decides, for each of a group of DAC channels, which code the converter actually receives and which power state it sits in. In normal operation each channel passes its register code through unchanged and takes its power state from a 2-bit software field that the block stores. Six asynchronous, active-low control pins can take over. Three of them force every channel's code to full scale, to midscale or to zero. One of them is a lockout that keeps all channels powered. Two of them force every channel into shutdown, each with its own output termination.

The pins are brought into the clock domain by a multi-stage synchroniser before any of them is used. The overrides mask the stored software field and never change it. When the lockout is released, a channel that software had shut down goes back to shutdown. The exception is a channel whose field was written while the lockout was held. That channel stays powered until software writes its field again after the release. Illegal pin combinations raise a conflict flag, and a fixed priority then resolves them.

Top module: `dac_out_override`

## Requirements
- R1: After reset every stored power-down field is 00, every channel state is 00 (on), each effective code equals its register code and the conflict flag is 0.
- R2: While the full-scale pin is low, every effective code is all ones. Once it is high again and the synchroniser has settled, the codes follow the register data.
- R3: While the midscale pin is low, every effective code has only its most significant bit set (0x800 for 12-bit codes).
- R4: While the zero pin is low, every effective code is 0.
- R5: When two or more of the full-scale, midscale and zero pins are low at once, the conflict flag is 1. Zero wins over midscale, and midscale wins over full scale.
- R6: A write strobe on a channel stores its 2-bit field at the clock edge. The state output then shows that field, using the encoding 00 on, 01 shutdown with 1 kΩ termination, 10 shutdown with 100 kΩ termination, 11 shutdown with high-impedance output. Channels without a strobe keep their fields.
- R7: While the lockout pin is low and no shutdown pin is low, every state is 00. When the lockout is released, each channel not written during the lockout shows its stored field again.
- R8: A channel whose field was written during the lockout shows state 00 after the release. It keeps showing 00 until its field is written with the lockout inactive, and from that write on it shows the new field.
- R9: While the 1 kΩ shutdown pin is low, every state is 01. While only the alternate shutdown pin is low, every state is 10 (11 when the high-impedance variant is selected). The 1 kΩ pin wins when both are low.
- R10: When the lockout pin and either shutdown pin are low together, the conflict flag is 1 and the shutdown pin decides the state.
- R11: A pin level set just before a rising edge reaches the outputs after the second rising edge and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_code_i | input | NUM_CH*CODE_W | Register code of each channel, channel 0 in the low bits |
| pd_wr_i | input | NUM_CH | Per-channel write strobe for the power-down field |
| pd_wdata_i | input | 2*NUM_CH | Power-down field write data, 2 bits per channel |
| full_n_i | input | 1 | Asynchronous active-low force to full scale |
| half_n_i | input | 1 | Asynchronous active-low force to midscale |
| zero_n_i | input | 1 | Asynchronous active-low force to zero |
| lock_n_i | input | 1 | Asynchronous active-low power-down lockout |
| sd_term_n_i | input | 1 | Asynchronous active-low shutdown with 1 kΩ termination |
| sd_alt_n_i | input | 1 | Asynchronous active-low shutdown with alternate termination |
| eff_code_o | output | NUM_CH*CODE_W | Effective code of each channel |
| pwr_state_o | output | 2*NUM_CH | Power state of each channel, 2 bits per channel |
| conflict_o | output | 1 | Illegal pin combination present |

## Verification
A corrupted stored power-down field stays hidden for as long as a lockout or shutdown pin masks it. It shows up on the state output in the same cycle the mask is lifted, so the bench checks right after each release and not only while a pin is held. A release-hold flag that is set or cleared wrongly shows as the wrong state after lockout release, either 00 where a shutdown code should be or the reverse. Synchroniser depth errors move output changes by whole cycles, so the bench samples one edge early and again at the expected edge.

// File: rtl/dac_ovr_pkg.sv
package dac_ovr_pkg;

   typedef enum logic [1:0] {
      PS_ON      = 2'b00,
      PS_SD_1K   = 2'b01,
      PS_SD_100K = 2'b10,
      PS_SD_HIZ  = 2'b11
   } pwr_state_e;

   // index of each control pin inside the synchronised pin vector
   localparam int PIN_FULL  = 0;
   localparam int PIN_HALF  = 1;
   localparam int PIN_ZERO  = 2;
   localparam int PIN_LOCK  = 3;
   localparam int PIN_SDT   = 4;
   localparam int PIN_SDA   = 5;
   localparam int PIN_COUNT = 6;

endpackage

// File: rtl/dac_pin_sync.sv
module dac_pin_sync #(
   parameter int   WIDTH   = 1,
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("dac_pin_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("dac_pin_sync: WIDTH must be at least 1");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= {STAGES{ {WIDTH{RST_VAL}} }};
      end else begin
         chain_q <= {chain_q[STAGES-2:0], async_i};
      end
   end

   assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/dac_code_force.sv
module dac_code_force #(
   parameter int NUM_CH = 4,
   parameter int CODE_W = 12
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_CH*CODE_W-1:0] reg_code_i,
   input  logic                     force_full_i,
   input  logic                     force_half_i,
   input  logic                     force_zero_i,
   output logic [NUM_CH*CODE_W-1:0] code_o
);

   localparam logic [CODE_W-1:0] CODE_FULL = {CODE_W{1'b1}};
   localparam logic [CODE_W-1:0] CODE_HALF = {1'b1, {(CODE_W-1){1'b0}}};
   localparam logic [CODE_W-1:0] CODE_ZERO = '0;

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      logic [CODE_W-1:0] reg_code;
      logic [CODE_W-1:0] out_code;

      assign reg_code = reg_code_i[ch*CODE_W +: CODE_W];

      // fixed priority: zero, then midscale, then full scale
      always_comb begin
         if (force_zero_i) begin
            out_code = CODE_ZERO;
         end else if (force_half_i) begin
            out_code = CODE_HALF;
         end else if (force_full_i) begin
            out_code = CODE_FULL;
         end else begin
            out_code = reg_code;
         end
      end

      assign code_o[ch*CODE_W +: CODE_W] = out_code;

      AST_FULL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
         (force_full_i && !force_half_i && !force_zero_i) |-> (code_o[ch*CODE_W +: CODE_W] == CODE_FULL)) // R2
         else $error("full-scale force not seen on channel %0d", ch);

      AST_HALF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
         (force_half_i && !force_zero_i) |-> (code_o[ch*CODE_W +: CODE_W] == CODE_HALF)) // R3
         else $error("midscale force not seen on channel %0d", ch);
   end

endmodule

// File: rtl/dac_pd_chan.sv
module dac_pd_chan
   import dac_ovr_pkg::*;
#(
   parameter bit ALT_HIZ = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_i,
   input  logic [1:0] wdata_i,
   input  logic       lock_i,
   input  logic       sd_term_i,
   input  logic       sd_alt_i,
   output logic [1:0] state_o
);

   localparam pwr_state_e ALT_STATE = ALT_HIZ ? PS_SD_HIZ : PS_SD_100K;

   logic [1:0] sw_q;
   logic       lock_q;
   logic       mod_q;
   logic       hold_q;
   logic       lock_rise;
   logic       mod_d;

   assign lock_rise = lock_i & ~lock_q;

   // modified flag: cleared when lockout asserts, set by any write
   always_comb begin
      if (wr_i) begin
         mod_d = 1'b1;
      end else if (lock_rise) begin
         mod_d = 1'b0;
      end else begin
         mod_d = mod_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sw_q   <= PS_ON;
         lock_q <= 1'b0;
         mod_q  <= 1'b0;
         hold_q <= 1'b0;
      end else begin
         if (wr_i) begin
            sw_q <= wdata_i;
         end
         lock_q <= lock_i;
         mod_q  <= mod_d;
         // during lockout the hold flag mirrors the modified flag; after
         // release it keeps the channel up until a write outside lockout
         if (lock_i) begin
            hold_q <= mod_d;
         end else if (wr_i) begin
            hold_q <= 1'b0;
         end
      end
   end

   always_comb begin
      if (sd_term_i) begin
         state_o = PS_SD_1K;
      end else if (sd_alt_i) begin
         state_o = ALT_STATE;
      end else if (lock_i || hold_q) begin
         state_o = PS_ON;
      end else begin
         state_o = sw_q;
      end
   end

   AST_LOCK_ON: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_i && !sd_term_i && !sd_alt_i) |-> (state_o == PS_ON)) // R7
      else $error("lockout did not keep channel powered");

   AST_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(lock_i) && !$past(mod_d) && !sd_term_i && !sd_alt_i) |-> (state_o == sw_q)) // R7
      else $error("stored state not restored after lockout");

   AST_HOLD_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (!lock_i && wr_i) |=> !hold_q) // R8
      else $error("write outside lockout did not clear hold");

   AST_SD_TERM: assert property (@(posedge clk) disable iff (!rst_n)
      sd_term_i |-> (state_o == PS_SD_1K)) // R9
      else $error("1k shutdown pin not obeyed");

endmodule

// File: rtl/dac_out_override.sv
module dac_out_override
   import dac_ovr_pkg::*;
#(
   parameter int NUM_CH      = 4,
   parameter int CODE_W      = 12,
   parameter int SYNC_STAGES = 2,
   parameter bit ALT_HIZ     = 1'b0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_CH*CODE_W-1:0] reg_code_i,
   input  logic [NUM_CH-1:0]        pd_wr_i,
   input  logic [2*NUM_CH-1:0]      pd_wdata_i,
   input  logic                     full_n_i,
   input  logic                     half_n_i,
   input  logic                     zero_n_i,
   input  logic                     lock_n_i,
   input  logic                     sd_term_n_i,
   input  logic                     sd_alt_n_i,
   output logic [NUM_CH*CODE_W-1:0] eff_code_o,
   output logic [2*NUM_CH-1:0]      pwr_state_o,
   output logic                     conflict_o
);

   if (NUM_CH < 1) begin : g_bad_ch
      $error("dac_out_override: NUM_CH must be at least 1");
   end
   if (CODE_W < 2) begin : g_bad_code
      $error("dac_out_override: CODE_W must be at least 2");
   end

   logic [PIN_COUNT-1:0] pins_n_raw;
   logic [PIN_COUNT-1:0] pins_n_sync;
   logic [PIN_COUNT-1:0] pin_act;
   logic                 force_conflict;
   logic                 lock_conflict;

   assign pins_n_raw[PIN_FULL] = full_n_i;
   assign pins_n_raw[PIN_HALF] = half_n_i;
   assign pins_n_raw[PIN_ZERO] = zero_n_i;
   assign pins_n_raw[PIN_LOCK] = lock_n_i;
   assign pins_n_raw[PIN_SDT]  = sd_term_n_i;
   assign pins_n_raw[PIN_SDA]  = sd_alt_n_i;

   dac_pin_sync #(
      .WIDTH   (PIN_COUNT),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b1)
   ) i_pin_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (pins_n_raw),
      .sync_o  (pins_n_sync)
   );

   assign pin_act = ~pins_n_sync;

   dac_code_force #(
      .NUM_CH (NUM_CH),
      .CODE_W (CODE_W)
   ) i_code_force (
      .clk          (clk),
      .rst_n        (rst_n),
      .reg_code_i   (reg_code_i),
      .force_full_i (pin_act[PIN_FULL]),
      .force_half_i (pin_act[PIN_HALF]),
      .force_zero_i (pin_act[PIN_ZERO]),
      .code_o       (eff_code_o)
   );

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_pd
      dac_pd_chan #(
         .ALT_HIZ (ALT_HIZ)
      ) i_pd_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_i      (pd_wr_i[ch]),
         .wdata_i   (pd_wdata_i[2*ch +: 2]),
         .lock_i    (pin_act[PIN_LOCK]),
         .sd_term_i (pin_act[PIN_SDT]),
         .sd_alt_i  (pin_act[PIN_SDA]),
         .state_o   (pwr_state_o[2*ch +: 2])
      );
   end

   always_comb begin
      force_conflict = (pin_act[PIN_FULL] & pin_act[PIN_HALF])
                     | (pin_act[PIN_FULL] & pin_act[PIN_ZERO])
                     | (pin_act[PIN_HALF] & pin_act[PIN_ZERO]);
      lock_conflict  = pin_act[PIN_LOCK] & (pin_act[PIN_SDT] | pin_act[PIN_SDA]);
      conflict_o     = force_conflict | lock_conflict;
   end

   AST_FORCE_CONFLICT: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones({pin_act[PIN_FULL], pin_act[PIN_HALF], pin_act[PIN_ZERO]}) > 1) |-> conflict_o) // R5
      else $error("force pin conflict not flagged");

   AST_ZERO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      pin_act[PIN_ZERO] |-> (eff_code_o == '0)) // R4
      else $error("zero force not seen at outputs");

   AST_LOCK_SD_CONFLICT: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_act[PIN_LOCK] && (pin_act[PIN_SDT] || pin_act[PIN_SDA])) |-> conflict_o) // R10
      else $error("lockout with shutdown not flagged");

   AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !conflict_o) // R1
      else $error("conflict after reset");

endmodule

// File: tb/test_dac_out_override.sv
`timescale 1ns/1ps
module test_dac_out_override;

   localparam int NCH = 4;
   localparam int CW  = 12;

   typedef struct {
      logic [NCH*CW-1:0] code;
      logic [2*NCH-1:0]  state;
      logic              conf;
      string             tag;
   } exp_t;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NCH*CW-1:0] reg_code;
   logic [NCH-1:0]    pd_wr = '0;
   logic [2*NCH-1:0]  pd_wdata = '0;
   logic full_n = 1'b1, half_n = 1'b1, zero_n = 1'b1;
   logic lock_n = 1'b1, sdt_n = 1'b1, sda_n = 1'b1;
   logic [NCH*CW-1:0] eff_code;
   logic [2*NCH-1:0]  pwr_state;
   logic              conflict;

   int   checks = 0;
   int   errors = 0;
   bit   done   = 1'b0;
   exp_t sb_q[$];

   localparam logic [NCH*CW-1:0] REGS  = {12'hABC, 12'h789, 12'h456, 12'h123};
   localparam logic [NCH*CW-1:0] FULLS = {NCH{12'hFFF}};
   localparam logic [NCH*CW-1:0] HALFS = {NCH{12'h800}};
   localparam logic [NCH*CW-1:0] ZEROS = '0;

   always #2 clk = ~clk;

   dac_out_override #(
      .NUM_CH (NCH),
      .CODE_W (CW)
   ) i_dac_out_override (
      .clk         (clk),
      .rst_n       (rst_n),
      .reg_code_i  (reg_code),
      .pd_wr_i     (pd_wr),
      .pd_wdata_i  (pd_wdata),
      .full_n_i    (full_n),
      .half_n_i    (half_n),
      .zero_n_i    (zero_n),
      .lock_n_i    (lock_n),
      .sd_term_n_i (sdt_n),
      .sd_alt_n_i  (sda_n),
      .eff_code_o  (eff_code),
      .pwr_state_o (pwr_state),
      .conflict_o  (conflict)
   );

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_out(input logic [NCH*CW-1:0] c, input logic [2*NCH-1:0] s,
                             input logic f, input string tag);
      exp_t e;
      e.code = c; e.state = s; e.conf = f; e.tag = tag;
      sb_q.push_back(e);
   endtask

   // active-high requests, driven as active-low pins
   task automatic set_pins(input bit f, input bit h, input bit z,
                           input bit l, input bit st, input bit sa);
      full_n = ~f; half_n = ~h; zero_n = ~z;
      lock_n = ~l; sdt_n  = ~st; sda_n  = ~sa;
   endtask

   task automatic write_pd(input logic [NCH-1:0] mask, input logic [2*NCH-1:0] data);
      pd_wr = mask; pd_wdata = data;
      step(1);
      pd_wr = '0;
   endtask

   // monitor: compares queued expectations shortly after each falling edge
   initial begin
      forever begin
         @(negedge clk);
         #1;
         while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (eff_code !== e.code || pwr_state !== e.state || conflict !== e.conf) begin
               errors++;
               $display("FAIL %s: code %h state %b conflict %b, expected code %h state %b conflict %b",
                        e.tag, eff_code, pwr_state, conflict, e.code, e.state, e.conf);
            end
         end
      end
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      reg_code = REGS;
      step(3);
      rst_n = 1'b1;
      step(1);
      expect_out(REGS, 8'b00_00_00_00, 1'b0, "R1 reset state");
      step(1);

      // R11 and R2: full-scale force, one edge early then at the second edge
      set_pins(1, 0, 0, 0, 0, 0);
      step(1);
      expect_out(REGS, 8'h00, 1'b0, "R11 no change after one edge");
      step(1);
      expect_out(FULLS, 8'h00, 1'b0, "R2 full scale forced");
      set_pins(0, 0, 0, 0, 0, 0);
      step(2);
      expect_out(REGS, 8'h00, 1'b0, "R2 release follows registers");

      // R3 midscale
      set_pins(0, 1, 0, 0, 0, 0);
      step(2);
      expect_out(HALFS, 8'h00, 1'b0, "R3 midscale forced");
      set_pins(0, 0, 0, 0, 0, 0);
      step(2);

      // R4 zero
      set_pins(0, 0, 1, 0, 0, 0);
      step(2);
      expect_out(ZEROS, 8'h00, 1'b0, "R4 zero forced");

      // R5 priorities and conflict
      set_pins(1, 0, 1, 0, 0, 0);
      step(2);
      expect_out(ZEROS, 8'h00, 1'b1, "R5 zero over full with conflict");
      set_pins(1, 1, 0, 0, 0, 0);
      step(2);
      expect_out(HALFS, 8'h00, 1'b1, "R5 mid over full with conflict");
      set_pins(0, 0, 0, 0, 0, 0);
      step(2);
      expect_out(REGS, 8'h00, 1'b0, "R5 conflict clears");

      // R6 software power-down fields
      write_pd(4'b1111, 8'b00_11_10_01);
      expect_out(REGS, 8'b00_11_10_01, 1'b0, "R6 fields stored");
      write_pd(4'b0001, 8'b11_11_11_00);
      expect_out(REGS, 8'b00_11_10_00, 1'b0, "R6 single channel write");
      write_pd(4'b0001, 8'b00_00_00_01);
      expect_out(REGS, 8'b00_11_10_01, 1'b0, "R6 rewrite channel 0");

      // R7 lockout masks then restores
      set_pins(0, 0, 0, 1, 0, 0);
      step(2);
      expect_out(REGS, 8'h00, 1'b0, "R7 lockout powers up");
      set_pins(0, 0, 0, 0, 0, 0);
      step(2);
      expect_out(REGS, 8'b00_11_10_01, 1'b0, "R7 shutdown returns");

      // R8 write during lockout cancels the return
      set_pins(0, 0, 0, 1, 0, 0);
      step(2);
      write_pd(4'b0010, 8'b00_11_11_01);
      expect_out(REGS, 8'h00, 1'b0, "R8 write during lockout masked");
      set_pins(0, 0, 0, 0, 0, 0);
      step(2);
      expect_out(REGS, 8'b00_11_00_01, 1'b0, "R8 written channel stays on");
      step(3);
      expect_out(REGS, 8'b00_11_00_01, 1'b0, "R8 hold persists");
      write_pd(4'b0010, 8'b00_11_10_01);
      expect_out(REGS, 8'b00_11_10_01, 1'b0, "R8 write after release applies");

      // R9 shutdown pins
      set_pins(0, 0, 0, 0, 1, 0);
      step(2);
      expect_out(REGS, 8'b01_01_01_01, 1'b0, "R9 1k shutdown");
      set_pins(0, 0, 0, 0, 0, 1);
      step(2);
      expect_out(REGS, 8'b10_10_10_10, 1'b0, "R9 alternate shutdown");
      set_pins(0, 0, 0, 0, 1, 1);
      step(2);
      expect_out(REGS, 8'b01_01_01_01, 1'b0, "R9 1k over alternate");

      // R10 lockout against shutdown
      set_pins(0, 0, 0, 1, 1, 0);
      step(2);
      expect_out(REGS, 8'b01_01_01_01, 1'b1, "R10 shutdown over lockout");
      set_pins(0, 0, 0, 1, 0, 1);
      step(2);
      expect_out(REGS, 8'b10_10_10_10, 1'b1, "R10 alternate over lockout");
      set_pins(0, 0, 0, 0, 0, 0);
      step(2);
      expect_out(REGS, 8'b00_11_10_01, 1'b0, "R10 stored fields after release");

      step(2);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule